// File: doc/BRIEF.md
# Daisy-Chainable Command and Status SPI Slave

This block is the serial command port of a four-channel power switch controller. An external master lowers chip select, clocks in 16-bit command words on the serial input and, during the same clocks, receives a 16-bit status word on the serial output. When chip select is released, the block counts the bits it received. Only a count that is a nonzero whole multiple of 16 commits the last received word. The commit appears on a register write port as a single-cycle strobe. Any other length is thrown away, and the block behaves as though that frame had never been sent.

The status word is built from the previous committed command and from a persistent read selection. Bit 15 holds that command's watchdog bit. Bits 14:10 hold its address. Bit 9 holds the normal-mode flag. Bits 8:0 hold a register picked by the stored selection code, and that code changes only when a command is written to the selection address. After the first 16 bits of a frame, the serial output repeats the serial input delayed by 16 clocks, so several devices can share one chip-select line in a chain.

All serial pins are oversampled in the system clock domain. SPI mode 0 is used: the input is taken at the rising SCK edge and the output moves after the falling SCK edge.

Top module: `hsw_spi_slave`

## Requirements
- R1: `so_oe` is 0 while chip select is high and 1 during a frame.
- R2: On chip-select fall the reply word is loaded and shifted out MSB first, one bit per SCK cycle.
- R3: Reply bits 15 and 14:10 are the watchdog bit and 5-bit address of the last committed command, both 0 after reset.
- R4: Reply bit 9 equals the `normal_mode` input.
- R5: Reply bits 8:0 come from a 5-bit selection code. Code[2:0] picks the kind: 0 fault, 1 PWM, 2 config0, 3 config1, 4 overcurrent, 5 global, 6 and 7 read zero. Code[4:3] picks the channel for kinds 0 to 4. Reset code is 0.
- R6: The selection code changes only when a committed command has address `SEL_ADDR` (default 0), and it is taken from that command's data bits 4:0. Commands to other addresses leave it unchanged.
- R7: In a frame longer than 16 bits, output bit i (i≥16) equals input bit i−16 of the same frame.
- R8: A frame whose bit count is a nonzero multiple of 16 gives exactly one `wr_stb` pulse of one clock. With it come `wr_wd`=word[15], `wr_addr`=word[14:10] and `wr_data`=word[9:0] of the last 16 bits received.
- R9: A frame of any other length, including zero bits, gives no strobe and changes neither the selection code nor the reply content.
- R10: The bit counter saturates at 2^CNT_W−1. A frame that reaches saturation is invalid (with CNT_W=8, a 272-bit frame is rejected).
- R11: A frame that starts one clock after the previous valid frame ends returns a reply that already reflects that frame's commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (tri-state control) |
| normal_mode | input | 1 | Device-in-normal-mode flag |
| fault_rd | input | 36 | Per-channel fault readback, channel c at [9c+8:9c] |
| pwm_rd | input | 36 | Per-channel PWM readback |
| cfg0_rd | input | 36 | Per-channel config0 readback |
| cfg1_rd | input | 36 | Per-channel config1 readback |
| ocr_rd | input | 36 | Per-channel overcurrent readback |
| glob_rd | input | 9 | Device-wide readback |
| wr_stb | output | 1 | Single-cycle commit strobe |
| wr_wd | output | 1 | Watchdog bit of committed word |
| wr_addr | output | 5 | Address of committed word |
| wr_data | output | 10 | Data of committed word |

## Verification
The commit of a finished frame and the reply load of the next frame can fall in the same system clock. This happens when chip select is high for a single clock between two frames, because the write strobe and the falling-edge load then coincide. The bench provokes this by writing a new selection code and dropping chip select again at the very next clock. It judges the result from the reply of the second frame, which must already show the new selection and the first frame's address and watchdog bit.

// File: rtl/hsw_spi_pkg.sv
package hsw_spi_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = WORD_W - 1 - ADDR_W;
  localparam int RD_W   = 9;
  localparam int CH_W   = 2;
  localparam int NCH    = 1 << CH_W;
  localparam int KIND_W = 3;
  localparam int SEL_W  = CH_W + KIND_W;

  typedef enum logic [KIND_W-1:0] {
    K_FAULT = 3'd0,
    K_PWM   = 3'd1,
    K_CFG0  = 3'd2,
    K_CFG1  = 3'd3,
    K_OCR   = 3'd4,
    K_GLOB  = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } kind_e;

  typedef struct packed {
    logic              wd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    kind_e           kind;
  } sel_t;

  // A frame counts only with a nonzero whole number of words and no saturation.
  function automatic logic frame_len_ok(input int unsigned nbits, input logic saturated);
    return !saturated && (nbits != 0) && ((nbits % WORD_W) == 0);
  endfunction

  // Reply layout: watchdog, address, mode flag, selected readback.
  function automatic logic [WORD_W-1:0] build_reply(input cmd_t prev, input logic nm,
                                                    input logic [RD_W-1:0] rd);
    return {prev.wd, prev.addr, nm, rd};
  endfunction

endpackage

// File: rtl/hsw_spi_sync.sv
module hsw_spi_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

endmodule

// File: rtl/hsw_spi_frame.sv
module hsw_spi_frame
  import hsw_spi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic [WORD_W-1:0] reply,
  output logic              so,
  output logic              so_oe,
  output cmd_t              rx_word,
  output logic              frame_ok,
  output logic              len_ok,
  output logic              cs_fall_evt,
  output logic              cs_rise_evt,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              cs_d, sck_d;
  logic              sck_rise_evt, sck_fall_evt;
  logic [WORD_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_n_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall_evt  =  cs_d & ~cs_n_s;
  assign cs_rise_evt  = ~cs_d &  cs_n_s;
  assign sck_rise_evt =  sck_s & ~sck_d;
  assign sck_fall_evt = ~sck_s &  sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (cs_fall_evt) begin
      cnt_q <= '0;
      tx_q  <= reply;
    end else if (!cs_n_s) begin
      if (sck_rise_evt) begin
        rx_q <= {rx_q[WORD_W-2:0], si_s};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_fall_evt) begin
        // newest received bit enters the tail: the echo appears 16 clocks later
        tx_q <= {tx_q[WORD_W-2:0], rx_q[0]};
      end
    end
  end

  assign len_ok   = frame_len_ok(32'(cnt_q), cnt_q == CNT_MAX);
  assign frame_ok = cs_rise_evt & len_ok;
  assign rx_word  = cmd_t'(rx_q);
  assign bit_cnt  = cnt_q;
  assign so       = tx_q[WORD_W-1];
  assign so_oe    = ~cs_n_s;

endmodule

// File: rtl/hsw_spi_regs.sv
module hsw_spi_regs
  import hsw_spi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SEL_ADDR = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_ok,
  input  cmd_t                  rx_word,
  input  logic                  normal_mode,
  input  logic [NCH*RD_W-1:0]   fault_rd,
  input  logic [NCH*RD_W-1:0]   pwm_rd,
  input  logic [NCH*RD_W-1:0]   cfg0_rd,
  input  logic [NCH*RD_W-1:0]   cfg1_rd,
  input  logic [NCH*RD_W-1:0]   ocr_rd,
  input  logic [RD_W-1:0]       glob_rd,
  output logic [WORD_W-1:0]     reply,
  output logic                  wr_stb,
  output logic                  wr_wd,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output sel_t                  sel_q
);

  logic pend_q;
  cmd_t cmd_q, prev_q, prev_eff;
  sel_t sel_eff;
  logic [RD_W-1:0] rd_val;

  logic [RD_W-1:0] fault_a [NCH];
  logic [RD_W-1:0] pwm_a   [NCH];
  logic [RD_W-1:0] cfg0_a  [NCH];
  logic [RD_W-1:0] cfg1_a  [NCH];
  logic [RD_W-1:0] ocr_a   [NCH];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign fault_a[c] = fault_rd[c*RD_W +: RD_W];
      assign pwm_a[c]   = pwm_rd[c*RD_W +: RD_W];
      assign cfg0_a[c]  = cfg0_rd[c*RD_W +: RD_W];
      assign cfg1_a[c]  = cfg1_rd[c*RD_W +: RD_W];
      assign ocr_a[c]   = ocr_rd[c*RD_W +: RD_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmd_q  <= '0;
      prev_q <= '0;
      sel_q  <= '{ch: '0, kind: K_FAULT};
    end else begin
      pend_q <= frame_ok;
      if (frame_ok) cmd_q <= rx_word;
      if (pend_q) begin
        prev_q <= cmd_q;
        if (cmd_q.addr == SEL_ADDR) sel_q <= sel_t'(cmd_q.data[SEL_W-1:0]);
      end
    end
  end

  // Forward a commit that coincides with the next reply load.
  always_comb begin
    prev_eff = prev_q;
    sel_eff  = sel_q;
    if (pend_q) begin
      prev_eff = cmd_q;
      if (cmd_q.addr == SEL_ADDR) sel_eff = sel_t'(cmd_q.data[SEL_W-1:0]);
    end
  end

  always_comb begin
    unique case (sel_eff.kind)
      K_FAULT: rd_val = fault_a[sel_eff.ch];
      K_PWM:   rd_val = pwm_a[sel_eff.ch];
      K_CFG0:  rd_val = cfg0_a[sel_eff.ch];
      K_CFG1:  rd_val = cfg1_a[sel_eff.ch];
      K_OCR:   rd_val = ocr_a[sel_eff.ch];
      K_GLOB:  rd_val = glob_rd;
      default: rd_val = '0;
    endcase
  end

  assign reply   = build_reply(prev_eff, normal_mode, rd_val);
  assign wr_stb  = pend_q;
  assign wr_wd   = cmd_q.wd;
  assign wr_addr = cmd_q.addr;
  assign wr_data = cmd_q.data;

endmodule

// File: rtl/hsw_spi_slave.sv
module hsw_spi_slave
  import hsw_spi_pkg::*;
#(
  parameter int                CNT_W    = 8,
  parameter int                SYNC_STG = 2,
  parameter logic [ADDR_W-1:0] SEL_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                cs_n,
  input  logic                si,
  output logic                so,
  output logic                so_oe,
  input  logic                normal_mode,
  input  logic [NCH*RD_W-1:0] fault_rd,
  input  logic [NCH*RD_W-1:0] pwm_rd,
  input  logic [NCH*RD_W-1:0] cfg0_rd,
  input  logic [NCH*RD_W-1:0] cfg1_rd,
  input  logic [NCH*RD_W-1:0] ocr_rd,
  input  logic [RD_W-1:0]     glob_rd,
  output logic                wr_stb,
  output logic                wr_wd,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data
);

  localparam int           NPIN     = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b001;

  logic [NPIN-1:0]   pin_s;
  logic [WORD_W-1:0] reply;
  cmd_t              rx_word;
  logic              frame_ok, len_ok, cs_fall_evt, cs_rise_evt;
  logic [CNT_W-1:0]  bit_cnt;
  sel_t              sel_q;

  hsw_spi_sync #(
    .W(NPIN), .STAGES(SYNC_STG), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din({si, sck, cs_n}), .level(pin_s)
  );

  hsw_spi_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pin_s[0]), .sck_s(pin_s[1]), .si_s(pin_s[2]),
    .reply(reply), .so(so), .so_oe(so_oe), .rx_word(rx_word),
    .frame_ok(frame_ok), .len_ok(len_ok),
    .cs_fall_evt(cs_fall_evt), .cs_rise_evt(cs_rise_evt), .bit_cnt(bit_cnt)
  );

  hsw_spi_regs #(.SEL_ADDR(SEL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .rx_word(rx_word),
    .normal_mode(normal_mode),
    .fault_rd(fault_rd), .pwm_rd(pwm_rd), .cfg0_rd(cfg0_rd),
    .cfg1_rd(cfg1_rd), .ocr_rd(ocr_rd), .glob_rd(glob_rd),
    .reply(reply), .wr_stb(wr_stb), .wr_wd(wr_wd),
    .wr_addr(wr_addr), .wr_data(wr_data), .sel_q(sel_q)
  );

endmodule

// File: rtl/hsw_spi_chk.sv
module hsw_spi_chk
  import hsw_spi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             cs_rise_evt,
  input logic             cs_fall_evt,
  input logic             len_ok,
  input logic             so_oe,
  input sel_t             sel_q,
  input logic [CNT_W-1:0] bit_cnt
);

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(cs_rise_evt && len_ok));

  // R9
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_evt && !len_ok) |=> !wr_stb);

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(sel_q));

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == '1 && !cs_fall_evt) |=> (bit_cnt == '1));

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |-> !so_oe);

endmodule

bind hsw_spi_slave hsw_spi_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cs_rise_evt(cs_rise_evt),
  .cs_fall_evt(cs_fall_evt), .len_ok(len_ok), .so_oe(so_oe),
  .sel_q(sel_q), .bit_cnt(bit_cnt)
);

// File: tb/hsw_spi_slave_tb.sv
module hsw_spi_slave_tb;
  import hsw_spi_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sck, cs_n, si, so, so_oe, normal_mode;
  logic [NCH*RD_W-1:0] fault_rd, pwm_rd, cfg0_rd, cfg1_rd, ocr_rd;
  logic [RD_W-1:0] glob_rd;
  logic wr_stb, wr_wd;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  hsw_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .normal_mode(normal_mode), .fault_rd(fault_rd), .pwm_rd(pwm_rd), .cfg0_rd(cfg0_rd),
    .cfg1_rd(cfg1_rd), .ocr_rd(ocr_rd), .glob_rd(glob_rd),
    .wr_stb(wr_stb), .wr_wd(wr_wd), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_bad = 0;
  logic tb_tx [0:299];
  logic tb_rx [0:299];
  logic [RD_W-1:0] v_fault [NCH], v_pwm [NCH], v_cfg0 [NCH], v_cfg1 [NCH], v_ocr [NCH];

  int stb_cnt = 0;
  logic cap_wd;
  logic [4:0] cap_addr;
  logic [9:0] cap_data;
  always @(posedge clk) if (wr_stb === 1'b1) begin
    stb_cnt++;
    cap_wd = wr_wd; cap_addr = wr_addr; cap_data = wr_data;
  end

  logic [15:0] m_prev = '0;
  logic [4:0]  m_sel  = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_rd(input logic [4:0] code);
    int c = int'(code[4:3]);
    case (code[2:0])
      3'd0: return v_fault[c];
      3'd1: return v_pwm[c];
      3'd2: return v_cfg0[c];
      3'd3: return v_cfg1[c];
      3'd4: return v_ocr[c];
      3'd5: return glob_rd;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [15:0] exp_reply();
    return {m_prev[15:10], normal_mode, exp_rd(m_sel)};
  endfunction

  function automatic void model_commit(input logic [15:0] w);
    m_prev = w;
    if (w[14:10] == 5'd0) m_sel = w[4:0];
  endfunction

  task automatic pack_inputs();
    for (int c = 0; c < NCH; c++) begin
      fault_rd[c*RD_W +: RD_W] = v_fault[c];
      pwm_rd[c*RD_W +: RD_W]   = v_pwm[c];
      cfg0_rd[c*RD_W +: RD_W]  = v_cfg0[c];
      cfg1_rd[c*RD_W +: RD_W]  = v_cfg1[c];
      ocr_rd[c*RD_W +: RD_W]   = v_ocr[c];
    end
  endtask

  task automatic load_word(input int off, input logic [15:0] w);
    for (int b = 0; b < 16; b++) tb_tx[off+b] = w[15-b];
  endtask

  function automatic logic [15:0] got_word(input int off);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[15-b] = tb_rx[off+b];
    return r;
  endfunction

  task automatic run_frame(input int nbits, input int hold);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 so_oe in frame", 32'(so_oe), 32'd1);
    for (int i = 0; i < nbits; i++) begin
      si = tb_tx[i];
      repeat (8) @(negedge clk);
      tb_rx[i] = so;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  // one valid 16-bit command with reply and commit checks
  task automatic xact(input string req, input logic [15:0] w);
    logic [15:0] exp;
    int s0 = stb_cnt;
    exp = exp_reply();
    load_word(0, w);
    run_frame(16, 12);
    chk({req, " reply"}, 32'(got_word(0)), 32'(exp));
    chk("R8 one strobe", stb_cnt, s0 + 1);
    chk("R8 write fields", {cap_wd, cap_addr, cap_data}, 32'(w));
    chk("R1 so_oe after frame", 32'(so_oe), 32'd0);
    model_commit(w);
  endtask

  task automatic t_reset();
    chk("R1 reset so_oe", 32'(so_oe), 32'd0);
    chk("R8 reset strobe", 32'(wr_stb), 32'd0);
  endtask

  task automatic t_basic();
    xact("R3 R2 first", {1'b1, 5'd3, 10'h155});
    xact("R3 prev fields", {1'b0, 5'd17, 10'h2AA});
    xact("R3 watchdog", {1'b1, 5'd31, 10'h3FF});
  endtask

  task automatic t_select();
    xact("R5 pwm ch2", {1'b0, 5'd0, 10'b00000_10_001});
    xact("R5 read pwm ch2", {1'b0, 5'd9, 10'h001});
    xact("R5 ocr ch3", {1'b1, 5'd0, 10'b00000_11_100});
    xact("R5 read ocr ch3", {1'b0, 5'd9, 10'h002});
    xact("R5 glob", {1'b0, 5'd0, 10'b00000_01_101});
    xact("R5 read glob", {1'b0, 5'd9, 10'h003});
    xact("R5 kind7", {1'b0, 5'd0, 10'b00000_00_111});
    xact("R5 read zero", {1'b0, 5'd9, 10'h004});
    xact("R5 cfg1 ch1", {1'b0, 5'd0, 10'b11111_01_011});
    xact("R5 read cfg1 ch1", {1'b0, 5'd9, 10'h005});
  endtask

  task automatic t_persist();
    xact("R6 keep1", {1'b0, 5'd12, 10'h01F});
    v_cfg1[1] = 9'h0C3; pack_inputs();
    xact("R6 keep2", {1'b1, 5'd7, 10'h000});
    xact("R6 keep3", {1'b0, 5'd1, 10'h3E0});
  endtask

  task automatic t_nm();
    normal_mode = 1'b0;
    xact("R4 mode low", {1'b0, 5'd4, 10'h0AA});
    normal_mode = 1'b1;
    xact("R4 mode high", {1'b0, 5'd4, 10'h055});
  endtask

  task automatic t_echo();
    logic [15:0] w1, w2, exp;
    int s0 = stb_cnt;
    w1 = {1'b1, 5'd0, 10'b00000_00_010};
    w2 = {1'b0, 5'd21, 10'h2C7};
    exp = exp_reply();
    load_word(0, w1);
    load_word(16, w2);
    run_frame(32, 12);
    chk("R2 reply in 32-bit frame", 32'(got_word(0)), 32'(exp));
    chk("R7 echo of first word", 32'(got_word(16)), 32'(w1));
    chk("R8 one strobe long frame", stb_cnt, s0 + 1);
    chk("R8 last word commits", {cap_wd, cap_addr, cap_data}, 32'(w2));
    model_commit(w2);
    xact("R6 echo frame kept sel", {1'b0, 5'd2, 10'h111});
  endtask

  task automatic t_invalid();
    int s0 = stb_cnt;
    load_word(0, {1'b1, 5'd0, 10'b00000_11_000});
    load_word(16, {1'b1, 5'd0, 10'b00000_11_000});
    run_frame(15, 12);
    run_frame(0, 12);
    run_frame(17, 12);
    run_frame(31, 12);
    chk("R9 no strobe on bad lengths", stb_cnt, s0);
    xact("R9 reply as if never sent", {1'b0, 5'd6, 10'h099});
  endtask

  task automatic t_sat();
    int s0 = stb_cnt;
    for (int i = 0; i < 272; i++) tb_tx[i] = 1'b0;
    run_frame(272, 12);
    chk("R10 saturated frame dropped", stb_cnt, s0);
    xact("R10 state unchanged", {1'b1, 5'd10, 10'h0F0});
  endtask

  task automatic t_b2b();
    logic [15:0] w1, w2, exp;
    int s0 = stb_cnt;
    w1 = {1'b1, 5'd0, 10'b00000_01_010};
    w2 = {1'b0, 5'd14, 10'h1A5};
    load_word(0, w1);
    run_frame(16, 1);
    model_commit(w1);
    exp = exp_reply();
    load_word(0, w2);
    run_frame(16, 12);
    chk("R11 reply after 1-clock gap", 32'(got_word(0)), 32'(exp));
    chk("R11 two strobes", stb_cnt, s0 + 2);
    model_commit(w2);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; normal_mode = 1'b1;
    glob_rd = 9'h1A7;
    for (int c = 0; c < NCH; c++) begin
      v_fault[c] = 9'h011 + 9'(c);
      v_pwm[c]   = 9'h0A2 + 9'(c * 5);
      v_cfg0[c]  = 9'h154 + 9'(c * 3);
      v_cfg1[c]  = 9'h1E1 + 9'(c * 7);
      v_ocr[c]   = 9'h0F3 + 9'(c * 9);
    end
    pack_inputs();
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic();
    t_select();
    t_persist();
    t_nm();
    t_echo();
    t_invalid();
    t_sat();
    t_b2b();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule